// File: doc/BRIEF.md
# Serial Management Frame Master (Dual Port)

This block runs clause-22 style management reads and writes on one of two serial management ports. One port faces an internal transceiver and the other an external one. A host presents a request: a port select, a 5-bit PHY address, a 5-bit register address, 16 bits of write data and a read/write flag. The block shifts the frame out on a divided management clock and returns the captured read data together with a one-cycle completion pulse.

The two ports have separate data outputs and separate data inputs. The management clock and the output enable are shared between them. The two ports sample their inputs at different points of the clock period. The block also runs a presence probe. The probe pulses the clock once with the outputs released, waits a programmable time, and then reports which transceiver holds its data line high.

A divider parameter sets the clock period. With the default setting and a 250 MHz system clock, the management clock runs at 2.5 MHz.

Top module: `mgmt_frame_master`

## Requirements
- R1: Out of reset and whenever idle, `mdc` is low, `md_oe` is low, both data outputs are high, `busy` is low. After reset, `rd_data` is 0 and `presence` is 2'b00.
- R2: Every transaction opens with 20 management clock periods. During these periods `md_oe` is high and both data outputs are high.
- R3: After the opening periods, the header goes out MSB first on the selected port: start code 01, opcode (01 = write, 10 = read), PHY address [4:0], register address [4:0]. The unselected port's data output stays high for the whole frame.
- R4: A write continues with turnaround bits 1 then 0, then 16 data bits MSB first. A write frame lasts 52 clock periods, with `md_oe` high in all of them.
- R5: Each phase of the clock (low, then high) lasts CLK_HALF system cycles. A driven bit or enable change happens only at the start of a low phase, so data is held across each rising edge. `done` rises 2*CLK_HALF*periods+1 cycles after the accepting edge.
- R6: A read releases `md_oe` from period 35 on (two turnaround periods). It then captures 16 bits MSB first into `rd_data` and clocks 3 more idle periods, for 55 periods in total. `rd_data` is valid when `done` is high.
- R7: The internal port (`req_ext`=0) samples its input at the end of the high phase, after the rising edge. The external port (`req_ext`=1) samples at the end of the low phase, just before the rising edge.
- R8: `done` is a single-cycle pulse with `busy` low. `busy` is high from the cycle after a request is accepted until `done`.
- R9: A request or probe start presented while `busy` is high is ignored. It does not alter the frame in progress and starts nothing afterwards.
- R10: A probe gives one clock pulse of CLK_HALF cycles with `md_oe` low, then waits PROBE_WAIT cycles and samples both inputs. `presence` becomes 2'b10 if the external input is high, 2'b01 if only the internal input is high, and 2'b00 if neither is high. `done` comes CLK_HALF+PROBE_WAIT+1 cycles after the accepting edge.
- R11: When a request and a probe start arrive in the same idle cycle, the request runs and the probe is dropped, leaving `presence` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_ext | input | 1 | Port select: 0 internal, 1 external |
| req_write | input | 1 | 1 write, 0 read |
| req_phy | input | 5 | PHY address |
| req_reg | input | 5 | Register address |
| req_wdata | input | 16 | Write data |
| probe_start | input | 1 | Start presence probe, taken when idle |
| busy | output | 1 | Transaction or probe in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | 16 | Captured read data |
| presence | output | 2 | Probe result: 00 none, 01 internal, 10 external |
| mdc | output | 1 | Management clock |
| md_oe | output | 1 | Shared data output enable |
| mdo_int | output | 1 | Internal port data output |
| mdo_ext | output | 1 | External port data output |
| mdi_int | input | 1 | Internal port data input |
| mdi_ext | input | 1 | External port data input |

## Verification
The bench builds the block with CLK_HALF=2 and PROBE_WAIT=40. Two-cycle phases let a modelled transceiver change its line partway through a phase. This makes the different sampling points of the internal and external ports visible as different captured words for the same line activity. The short probe wait keeps each probe to a few dozen cycles while still running the wait counter to its terminal value. The exact completion latencies of both frame lengths and of the probe can then be checked against the formulas.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;

    localparam int N_PRE  = 20;
    localparam int N_HDR  = 14;
    localparam int N_TA   = 2;
    localparam int N_DATA = 16;
    localparam int N_TAIL = 3;
    localparam int FRAME_W = N_HDR + N_TA + N_DATA;
    localparam int N_WR    = N_PRE + FRAME_W;
    localparam int N_RD    = N_WR + N_TAIL;
    localparam int BIT_CW  = $clog2(N_RD + 1);

    typedef logic [BIT_CW-1:0] bit_cnt_t;

    localparam bit_cnt_t PRE_BITS   = bit_cnt_t'(N_PRE);
    localparam bit_cnt_t RD_DRIVEN  = bit_cnt_t'(N_PRE + N_HDR);
    localparam bit_cnt_t WR_DRIVEN  = bit_cnt_t'(N_WR);
    localparam bit_cnt_t WR_LAST    = bit_cnt_t'(N_WR - 1);
    localparam bit_cnt_t RD_LAST    = bit_cnt_t'(N_RD - 1);
    localparam bit_cnt_t CAP_FIRST  = bit_cnt_t'(N_PRE + N_HDR + N_TA);
    localparam bit_cnt_t CAP_LAST   = bit_cnt_t'(N_PRE + N_HDR + N_TA + N_DATA - 1);

    localparam logic [1:0] START_CODE = 2'b01;
    localparam logic [1:0] OP_WRITE   = 2'b01;
    localparam logic [1:0] OP_READ    = 2'b10;
    localparam logic [1:0] TA_WRITE   = 2'b10;

    typedef enum logic [1:0] {
        PRES_NONE = 2'b00,
        PRES_INT  = 2'b01,
        PRES_EXT  = 2'b10
    } presence_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FRAME,
        ST_PROBE_CLK,
        ST_PROBE_WAIT
    } seq_state_e;

    typedef struct packed {
        logic        ext;
        logic        write;
        logic [4:0]  phy;
        logic [4:0]  regad;
        logic [15:0] wdata;
    } mgmt_req_t;

    function automatic logic [FRAME_W-1:0] build_frame(mgmt_req_t r);
        return {START_CODE, (r.write ? OP_WRITE : OP_READ), r.phy, r.regad,
                TA_WRITE, r.wdata};
    endfunction

    function automatic presence_e decode_presence(logic int_line, logic ext_line);
        if (ext_line)      return PRES_EXT;
        else if (int_line) return PRES_INT;
        else               return PRES_NONE;
    endfunction

endpackage

// File: rtl/mgmt_div.sv
module mgmt_div #(
    parameter int CLK_HALF = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic tick
);
    localparam int CW = (CLK_HALF > 1) ? $clog2(CLK_HALF) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(CLK_HALF - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clear)
            cnt <= '0;
        else if (cnt == CNT_LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = !clear && (cnt == CNT_LAST);

endmodule

// File: rtl/mgmt_seq.sv
module mgmt_seq
    import mgmt_pkg::*;
#(
    parameter int PROBE_WAIT = 50000
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      req_valid,
    input  mgmt_req_t req,
    input  logic      probe_start,
    output logic      busy,
    output logic      done,
    output logic      div_clear,
    output logic      mdc,
    output logic      md_oe,
    output logic      drive_bit,
    output logic      cur_port,
    output logic      cap_en,
    output logic      probe_sample
);
    localparam int WCW = (PROBE_WAIT > 1) ? $clog2(PROBE_WAIT) : 1;
    localparam logic [WCW-1:0] WAIT_LAST = WCW'(PROBE_WAIT - 1);

    seq_state_e          state;
    logic                phase;
    bit_cnt_t            bit_idx;
    logic [FRAME_W-1:0]  shreg;
    logic                port_q;
    logic                write_q;
    logic [WCW-1:0]      wait_cnt;

    bit_cnt_t last_bit;
    bit_cnt_t drive_end;
    logic     in_data;
    logic     at_sample_phase;

    always_comb begin
        last_bit        = write_q ? WR_LAST : RD_LAST;
        drive_end       = write_q ? WR_DRIVEN : RD_DRIVEN;
        busy            = (state != ST_IDLE);
        div_clear       = (state == ST_IDLE) || (state == ST_PROBE_WAIT);
        mdc             = phase;
        md_oe           = (state == ST_FRAME) && (bit_idx < drive_end);
        drive_bit       = (bit_idx < PRE_BITS) ? 1'b1 : shreg[FRAME_W-1];
        cur_port        = port_q;
        in_data         = (bit_idx >= CAP_FIRST) && (bit_idx <= CAP_LAST);
        // external samples late in the low phase, internal late in the high phase
        at_sample_phase = port_q ? !phase : phase;
        cap_en          = (state == ST_FRAME) && tick && !write_q && in_data
                          && at_sample_phase;
        probe_sample    = (state == ST_PROBE_WAIT) && (wait_cnt == WAIT_LAST);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            phase    <= 1'b0;
            bit_idx  <= '0;
            shreg    <= '0;
            port_q   <= 1'b0;
            write_q  <= 1'b0;
            wait_cnt <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state   <= ST_FRAME;
                        phase   <= 1'b0;
                        bit_idx <= '0;
                        shreg   <= build_frame(req);
                        port_q  <= req.ext;
                        write_q <= req.write;
                    end else if (probe_start) begin
                        state <= ST_PROBE_CLK;
                        phase <= 1'b1;
                    end
                end
                ST_FRAME: begin
                    if (tick) begin
                        if (!phase) begin
                            phase <= 1'b1;
                        end else begin
                            phase <= 1'b0;
                            if (bit_idx >= PRE_BITS)
                                shreg <= {shreg[FRAME_W-2:0], 1'b1};
                            if (bit_idx == last_bit) begin
                                state   <= ST_IDLE;
                                bit_idx <= '0;
                                done    <= 1'b1;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                end
                ST_PROBE_CLK: begin
                    if (tick) begin
                        phase    <= 1'b0;
                        state    <= ST_PROBE_WAIT;
                        wait_cnt <= '0;
                    end
                end
                ST_PROBE_WAIT: begin
                    if (wait_cnt == WAIT_LAST) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        wait_cnt <= wait_cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    AST_DRIVE_IN_LOW: assert property (@(posedge clk) disable iff (rst)
        ((drive_bit != $past(drive_bit)) || (md_oe != $past(md_oe))) |-> !phase); // R5
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R8
    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy); // R8
    AST_REFUSE_BUSY: assert property (@(posedge clk) disable iff (rst)
        (busy && req_valid) |=> ($stable(port_q) && $stable(write_q))); // R9
    AST_PROBE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROBE_WAIT) |-> (!phase && !md_oe)); // R10
    AST_BIT_RANGE: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FRAME) |-> (bit_idx <= last_bit)); // R4

endmodule

// File: rtl/mgmt_capture.sv
module mgmt_capture
    import mgmt_pkg::*;
#(
    parameter int NUM_PORTS = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        cap_en,
    input  logic        port_sel,
    input  logic        mdi_int,
    input  logic        mdi_ext,
    input  logic        probe_sample,
    output logic [15:0] rd_data,
    output presence_e   presence
);
    logic [NUM_PORTS-1:0] mdi_vec;
    logic                 sel_bit;

    assign mdi_vec = {mdi_ext, mdi_int};
    assign sel_bit = mdi_vec[port_sel];

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data  <= '0;
            presence <= PRES_NONE;
        end else begin
            if (cap_en)
                rd_data <= {rd_data[14:0], sel_bit};
            if (probe_sample)
                presence <= decode_presence(mdi_int, mdi_ext);
        end
    end

endmodule

// File: rtl/mgmt_frame_master.sv
module mgmt_frame_master
    import mgmt_pkg::*;
#(
    parameter int CLK_HALF   = 50,
    parameter int PROBE_WAIT = 50000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_ext,
    input  logic        req_write,
    input  logic [4:0]  req_phy,
    input  logic [4:0]  req_reg,
    input  logic [15:0] req_wdata,
    input  logic        probe_start,
    output logic        busy,
    output logic        done,
    output logic [15:0] rd_data,
    output logic [1:0]  presence,
    output logic        mdc,
    output logic        md_oe,
    output logic        mdo_int,
    output logic        mdo_ext,
    input  logic        mdi_int,
    input  logic        mdi_ext
);
    localparam int NUM_PORTS = 2;

    mgmt_req_t            req;
    logic                 tick;
    logic                 div_clear;
    logic                 drive_bit;
    logic                 cur_port;
    logic                 cap_en;
    logic                 probe_sample;
    logic [NUM_PORTS-1:0] mdo_vec;
    presence_e            pres;

    assign req = '{ext: req_ext, write: req_write, phy: req_phy,
                   regad: req_reg, wdata: req_wdata};

    mgmt_div #(.CLK_HALF(CLK_HALF)) u_div (
        .clk   (clk),
        .rst   (rst),
        .clear (div_clear),
        .tick  (tick)
    );

    mgmt_seq #(.PROBE_WAIT(PROBE_WAIT)) u_seq (
        .clk          (clk),
        .rst          (rst),
        .tick         (tick),
        .req_valid    (req_valid),
        .req          (req),
        .probe_start  (probe_start),
        .busy         (busy),
        .done         (done),
        .div_clear    (div_clear),
        .mdc          (mdc),
        .md_oe        (md_oe),
        .drive_bit    (drive_bit),
        .cur_port     (cur_port),
        .cap_en       (cap_en),
        .probe_sample (probe_sample)
    );

    mgmt_capture #(.NUM_PORTS(NUM_PORTS)) u_cap (
        .clk          (clk),
        .rst          (rst),
        .cap_en       (cap_en),
        .port_sel     (cur_port),
        .mdi_int      (mdi_int),
        .mdi_ext      (mdi_ext),
        .probe_sample (probe_sample),
        .rd_data      (rd_data),
        .presence     (pres)
    );

    // only the selected port carries frame bits; the other idles high
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        assign mdo_vec[p] = (md_oe && (cur_port == 1'(p))) ? drive_bit : 1'b1;
    end

    assign mdo_int  = mdo_vec[0];
    assign mdo_ext  = mdo_vec[1];
    assign presence = pres;

    AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!mdc && !md_oe && mdo_int && mdo_ext)); // R1
    AST_CAP_RELEASED: assert property (@(posedge clk) disable iff (rst)
        cap_en |-> !md_oe); // R6

endmodule

// File: tb/sim_mgmt_frame_master.sv
`timescale 1ns/1ps
module sim_mgmt_frame_master;
    localparam int HALF = 2;
    localparam int PW   = 40;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_ext = 1'b0, req_write = 1'b0;
    logic [4:0]  req_phy = '0, req_reg = '0;
    logic [15:0] req_wdata = '0;
    logic        probe_start = 1'b0;
    logic        busy, done, mdc, md_oe, mdo_int, mdo_ext;
    logic [15:0] rd_data;
    logic [1:0]  presence;
    logic        mdi_int = 1'b1, mdi_ext = 1'b1;

    always #2 clk = ~clk;

    mgmt_frame_master #(.CLK_HALF(HALF), .PROBE_WAIT(PW)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ext(req_ext),
        .req_write(req_write), .req_phy(req_phy), .req_reg(req_reg),
        .req_wdata(req_wdata), .probe_start(probe_start), .busy(busy),
        .done(done), .rd_data(rd_data), .presence(presence), .mdc(mdc),
        .md_oe(md_oe), .mdo_int(mdo_int), .mdo_ext(mdo_ext),
        .mdi_int(mdi_int), .mdi_ext(mdi_ext)
    );

    int errs = 0;
    int checks = 0;

    // bench-side view of the line activity
    logic        sel = 1'b0, late = 1'b0, phy_on = 1'b0;
    logic        pr_int = 1'b0, pr_ext = 1'b0;
    logic [15:0] phy_data = '0;
    logic        mon_clr = 1'b0;
    logic        mdc_q = 1'b0;
    int          rises = 0, falls = 0, out_n = 0;
    logic [63:0] out_bits = '0;
    logic        oth_low = 1'b0, oe_seen = 1'b0;

    always @(posedge clk) begin
        if (mon_clr) begin
            rises <= 0; falls <= 0; out_n <= 0; out_bits <= '0;
            oth_low <= 1'b0; oe_seen <= 1'b0; mdc_q <= 1'b0;
        end else begin
            mdc_q <= mdc;
            if (mdc && !mdc_q) begin
                rises <= rises + 1;
                if (md_oe) begin
                    out_bits <= {out_bits[62:0], (sel ? mdo_ext : mdo_int)};
                    out_n    <= out_n + 1;
                end
            end
            if (!mdc && mdc_q) falls <= falls + 1;
            if (busy && ((sel ? mdo_int : mdo_ext) == 1'b0)) oth_low <= 1'b1;
            if (md_oe) oe_seen <= 1'b1;
        end
    end

    function automatic logic phy_bit(int idx, logic [15:0] d);
        if (idx >= 36 && idx <= 51) return d[51-idx];
        return 1'b1;
    endfunction

    // modelled transceiver: early mode changes after a fall, late mode after a rise
    always @(negedge clk) begin
        logic v;
        if (phy_on) begin
            if (late) v = (rises > 0) ? phy_bit(rises - 1, phy_data) : 1'b1;
            else      v = phy_bit(falls, phy_data);
            if (sel) begin mdi_ext = v;  mdi_int = ~v; end
            else     begin mdi_int = v;  mdi_ext = ~v; end
        end else begin
            mdi_int = pr_int;
            mdi_ext = pr_ext;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic run_req(input logic ext, input logic wr, input logic lt,
                           input logic [4:0] phy, input logic [4:0] rg,
                           input logic [15:0] d, input bit with_probe,
                           input bit poke, output int lat);
        @(negedge clk);
        sel = ext; late = lt; phy_data = d; phy_on = 1'b1;
        req_ext = ext; req_write = wr; req_phy = phy; req_reg = rg;
        req_wdata = d; req_valid = 1'b1; probe_start = with_probe; mon_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; probe_start = 1'b0; mon_clr = 1'b0;
        lat = 1;
        chk(busy == 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
            if (poke && lat == 10) begin
                req_valid = 1'b1; req_ext = ~ext; req_write = 1'b1;
                req_wdata = 16'hFFFF; probe_start = 1'b1;
            end
            if (poke && lat == 11) begin
                req_valid = 1'b0; probe_start = 1'b0;
            end
        end
    endtask

    task automatic run_probe(input logic li, input logic le, output int lat);
        @(negedge clk);
        phy_on = 1'b0; pr_int = li; pr_ext = le;
        @(negedge clk);
        probe_start = 1'b1; mon_clr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        probe_start = 1'b0; mon_clr = 1'b0;
        lat = 1;
        while (!done && lat < 3000) begin
            @(negedge clk);
            lat++;
        end
    endtask

    // fields: [28] ext, [27] write, [26] late, [25:21] phy, [20:16] reg, [15:0] data
    localparam int NV = 7;
    localparam logic [31:0] VEC [NV] = '{
        {3'b0, 1'b0, 1'b1, 1'b0, 5'h01, 5'h00, 16'hA5C3},
        {3'b0, 1'b1, 1'b1, 1'b0, 5'h1F, 5'h1F, 16'h0001},
        {3'b0, 1'b0, 1'b0, 1'b0, 5'h03, 5'h02, 16'h1234},
        {3'b0, 1'b1, 1'b0, 1'b0, 5'h10, 5'h05, 16'hBEEF},
        {3'b0, 1'b0, 1'b0, 1'b1, 5'h0A, 5'h11, 16'h8001},
        {3'b0, 1'b1, 1'b0, 1'b1, 5'h15, 5'h0E, 16'h8001},
        {3'b0, 1'b1, 1'b0, 1'b1, 5'h00, 5'h01, 16'h0000}
    };

    initial begin
        repeat (200000) @(posedge clk);
        errs++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        int lat;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset and idle state
        chk(!mdc && !md_oe && mdo_int && mdo_ext && !busy && !done,
            "R1 idle lines", {58'b0, mdc, md_oe, mdo_int, mdo_ext, busy, done},
            64'b001100);
        chk(rd_data == 16'h0 && presence == 2'b00, "R1 reset data",
            {46'b0, presence, rd_data}, 64'h0);

        for (int i = 0; i < NV; i++) begin
            logic e, w, l;
            logic [4:0] ph, rg;
            logic [15:0] d, exp_rd;
            logic [63:0] exp_bits;
            int exp_n, exp_r;
            e = VEC[i][28]; w = VEC[i][27]; l = VEC[i][26];
            ph = VEC[i][25:21]; rg = VEC[i][20:16]; d = VEC[i][15:0];
            run_req(e, w, l, ph, rg, d, 1'b0, 1'b0, lat);
            if (w) begin
                exp_bits = 64'({20'hFFFFF, 2'b01, 2'b01, ph, rg, 2'b10, d});
                exp_n = 52; exp_r = 52;
            end else begin
                exp_bits = 64'({20'hFFFFF, 2'b01, 2'b10, ph, rg});
                exp_n = 34; exp_r = 55;
            end
            chk(out_bits == exp_bits, "R2 R3 R4 driven bits", out_bits, exp_bits);
            chk(out_n == exp_n, "R2 R6 enabled periods", 64'(out_n), 64'(exp_n));
            chk(rises == exp_r, "R4 R6 clock periods", 64'(rises), 64'(exp_r));
            chk(lat == 2*HALF*exp_r + 1, "R5 R8 done latency", 64'(lat),
                64'(2*HALF*exp_r + 1));
            chk(!oth_low, "R3 unselected port high", 64'(oth_low), 64'd0);
            if (!w) begin
                exp_rd = (e && l) ? {1'b1, d[15:1]} : d;
                chk(rd_data == exp_rd, "R6 R7 read data", 64'(rd_data), 64'(exp_rd));
            end
            @(negedge clk);
            chk(!done && !busy, "R8 done single pulse", {62'b0, done, busy}, 64'd0);
        end

        // R10: presence probe outcomes
        run_probe(1'b0, 1'b1, lat);
        chk(presence == 2'b10, "R10 ext present", 64'(presence), 64'h2);
        chk(lat == HALF + PW + 1, "R10 probe latency", 64'(lat), 64'(HALF + PW + 1));
        chk(rises == 1 && !oe_seen, "R10 one pulse released",
            {62'b0, oe_seen, 1'b0} | 64'(rises), 64'd1);
        run_probe(1'b1, 1'b1, lat);
        chk(presence == 2'b10, "R10 both high prefers ext", 64'(presence), 64'h2);
        run_probe(1'b1, 1'b0, lat);
        chk(presence == 2'b01, "R10 int present", 64'(presence), 64'h1);
        run_probe(1'b0, 1'b0, lat);
        chk(presence == 2'b00, "R10 none present", 64'(presence), 64'h0);
        run_probe(1'b1, 1'b0, lat);
        chk(presence == 2'b01, "R10 int again", 64'(presence), 64'h1);

        // R9: requests and probe starts during a frame are ignored
        run_req(1'b0, 1'b1, 1'b0, 5'h07, 5'h09, 16'h3C5A, 1'b0, 1'b1, lat);
        chk(out_bits == 64'({20'hFFFFF, 2'b01, 2'b01, 5'h07, 5'h09, 2'b10, 16'h3C5A}),
            "R9 frame unaltered", out_bits,
            64'({20'hFFFFF, 2'b01, 2'b01, 5'h07, 5'h09, 2'b10, 16'h3C5A}));
        chk(lat == 2*HALF*52 + 1, "R9 latency unaltered", 64'(lat), 64'(2*HALF*52 + 1));
        repeat (30) @(negedge clk);
        chk(!busy && rises == 52 && presence == 2'b01, "R9 nothing started later",
            {61'b0, busy, presence} | (64'(rises) << 8), 64'(52 << 8) | 64'h1);

        // R11: request wins over a simultaneous probe start
        run_req(1'b1, 1'b1, 1'b0, 5'h12, 5'h03, 16'h0F0F, 1'b1, 1'b0, lat);
        chk(rises == 52 && lat == 2*HALF*52 + 1, "R11 request taken",
            64'(rises), 64'd52);
        repeat (60) @(negedge clk);
        chk(!busy && presence == 2'b01, "R11 probe dropped",
            {61'b0, busy, presence}, 64'h1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule